// File: doc/BRIEF.md
# Branch Trace Address Queue

This block keeps a short history of taken-branch events for debug trace. Each event arrives on a capture port as a source address, a destination address, a fetch-position code and an interrupt marker. It is placed at the bottom of a four-slot shift queue, and the older events move up by one. When the queue is full, the oldest event falls off the top. For an interrupt event the destination captured is the first address of the handler. A very short repeat loop has no known destination, so its event is stored but marked invalid.

A debug host drains the queue one word at a time. It reads the flag word, then the source address, then the destination address of the oldest stored event. The entry is removed only when that three-read sequence completes with full-width address reads. A second pointer, the trace pointer, follows execution through the stored pairs. Each capture moves it up and each executed pair moves it back toward the bottom. Re-enabling capture invalidates every stored event and sends the trace pointer back to the bottom. The read position (the entry count) is left unchanged.

Top module: `branch_trace_queue`

## Requirements
- R1: After reset, level_o is 0, trace_ptr_o is 0, valid_o is all zero, and every read returns 0.
- R2: An event is captured when cap_valid_i is high and trace_en_i was high in this cycle and the previous one. It enters slot 0 and shifts older slots up. level_o rises by one and saturates at 4, and the oldest event is dropped when the queue is full.
- R3: rd_sel_i selects the word of the oldest stored entry (slot level_o-1): 0 = flag word, 1 = source, 2 = destination, 3 = reserved (reads 0). The flag word has bit 31 = valid, bit 30 = interrupt, bits 1:0 = fetch position, and all other bits 0. Reads return 0 when the queue is empty, when the entry is invalid, or when rd_en_i is low.
- R4: A source or destination read with rd_full_i low returns 0. It neither advances nor restarts the read sequence.
- R5: An entry is popped (level_o drops by one) only on a full destination read that directly follows a flag read and then a full source read. A full read out of that order, or a reserved read, restarts the sequence. A flag read always starts a new sequence.
- R6: A capture and a pop in the same cycle are both performed. level_o stays the same and the new event enters slot 0.
- R7: trace_ptr_o is the number of captured, not-yet-executed pairs minus one, saturating at 3. It reads 0 when there are none. Each capture moves it up and each exec_i pulse moves it down, stopping at the bottom.
- R8: Raising trace_en_i from low to high clears every valid flag, keeps level_o, and sets trace_ptr_o to 0. No event is captured while trace_en_i is low or in the first cycle it is high again.
- R9: An event captured with cap_dst_known_i low takes a slot and counts in level_o, but is stored invalid. Its valid_o bit is clear and all three of its words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Capture enable |
| cap_valid_i | input | 1 | Branch event present |
| cap_src_i | input | 32 | Branch source address |
| cap_dst_i | input | 32 | Branch destination (handler start for interrupts) |
| cap_pos_i | input | 2 | Fetch-position code |
| cap_irq_i | input | 1 | Event is an interrupt |
| cap_dst_known_i | input | 1 | Destination is known; low stores the event invalid |
| exec_i | input | 1 | A stored pair has been executed |
| rd_en_i | input | 1 | Host read strobe |
| rd_sel_i | input | 2 | Word select: 0 flag, 1 source, 2 destination |
| rd_full_i | input | 1 | Read is a full 32-bit access |
| rd_data_o | output | 32 | Read data for the current strobe |
| level_o | output | 3 | Stored entry count; the head is slot level_o-1 |
| trace_ptr_o | output | 2 | Trace pointer slot index |
| valid_o | output | 4 | Per-slot valid flags for occupied slots |

## Verification
The bench covers overflow at four entries: a design that kept the newest event out, or that kept counting, would report the wrong head and a level above 4. It interrupts the read sequence with narrow and out-of-order accesses: a design that popped on any destination read, or reset on a narrow access, would lose entries. It captures and pops in the same cycle, where a design that handled only one of the two would shift the level. It toggles the enable, where a design that cleared the level or kept the trace pointer would diverge from the expected pointer and read values.

// File: rtl/btq_pkg.sv
`timescale 1ns/1ps
package btq_pkg;
  localparam int ADDR_W = 32;
  localparam int POS_W  = 2;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_DST  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic              vld;
    logic              irq;
    logic [POS_W-1:0]  pos;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } entry_t;
endpackage

// File: rtl/btq_store.sv
`timescale 1ns/1ps
module btq_store
  import btq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic                  clr_i,
  input  entry_t                push_e_i,
  output entry_t [DEPTH-1:0]    slots_o
);
  entry_t [DEPTH-1:0] slots_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    entry_t shift_in;
    if (g == 0) begin : g_bot
      assign shift_in = push_e_i;
    end else begin : g_up
      assign shift_in = slots_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slots_q[g] <= '0;
      end else if (push_i) begin
        slots_q[g] <= shift_in;
      end else if (clr_i) begin
        slots_q[g].vld <= 1'b0;
      end
    end
  end

  assign slots_o = slots_q;
endmodule

// File: rtl/btq_rd_seq.sv
`timescale 1ns/1ps
module btq_rd_seq
  import btq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rd_en_i,
  input  rd_sel_e rd_sel_i,
  input  logic    rd_full_i,
  input  logic    nonempty_i,
  output logic    pop_o
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_FLAG, SQ_SRC} seq_e;
  seq_e seq_q, seq_d;

  always_comb begin
    seq_d = seq_q;
    if (rd_en_i) begin
      unique case (rd_sel_i)
        SEL_FLAG: seq_d = SQ_FLAG;
        SEL_SRC:  if (rd_full_i) seq_d = (seq_q == SQ_FLAG) ? SQ_SRC : SQ_IDLE;
        SEL_DST:  if (rd_full_i) seq_d = SQ_IDLE;
        default:  seq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seq_q <= SQ_IDLE;
    else         seq_q <= seq_d;
  end

  assign pop_o = rd_en_i && (rd_sel_i == SEL_DST) && rd_full_i &&
                 (seq_q == SQ_SRC) && nonempty_i;
endmodule

// File: rtl/btq_trace_ptr.sv
`timescale 1ns/1ps
module btq_trace_ptr #(
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          cap_i,
  input  logic          exec_i,
  output logic [PW-1:0] ptr_o
);
  logic [CW-1:0] pend_q;
  logic [CW:0]   sum;
  logic          dec;

  // executing with nothing pending is ignored
  assign dec = exec_i && (pend_q != '0);
  assign sum = {1'b0, pend_q} + (CW+1)'(cap_i) - (CW+1)'(dec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= '0;
    else if (restart_i)                 pend_q <= '0;
    else if (sum > (CW+1)'(DEPTH))      pend_q <= CW'(DEPTH);
    else                                pend_q <= sum[CW-1:0];
  end

  assign ptr_o = (pend_q == '0) ? '0 : PW'(pend_q - 1'b1);
endmodule

// File: rtl/branch_trace_queue.sv
`timescale 1ns/1ps
module branch_trace_queue
  import btq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_en_i,
  input  logic              cap_valid_i,
  input  logic [ADDR_W-1:0] cap_src_i,
  input  logic [ADDR_W-1:0] cap_dst_i,
  input  logic [POS_W-1:0]  cap_pos_i,
  input  logic              cap_irq_i,
  input  logic              cap_dst_known_i,
  input  logic              exec_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  input  logic              rd_full_i,
  output logic [31:0]       rd_data_o,
  output logic [LW-1:0]     level_o,
  output logic [PW-1:0]     trace_ptr_o,
  output logic [DEPTH-1:0]  valid_o
);
  logic               en_q, en_rise, cap_ok, pop;
  logic [LW-1:0]      level_q;
  logic [LW:0]        level_sum;
  entry_t             new_e, head;
  entry_t [DEPTH-1:0] slots;
  rd_sel_e            sel;

  assign sel     = rd_sel_e'(rd_sel_i);
  assign en_rise = trace_en_i && !en_q;
  assign cap_ok  = trace_en_i && en_q && cap_valid_i;

  always_comb begin
    new_e     = '0;
    new_e.vld = cap_dst_known_i;
    new_e.irq = cap_irq_i;
    new_e.pos = cap_pos_i;
    new_e.src = cap_src_i;
    new_e.dst = cap_dst_i;
  end

  btq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (cap_ok),
    .clr_i    (en_rise),
    .push_e_i (new_e),
    .slots_o  (slots)
  );

  btq_rd_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (sel),
    .rd_full_i  (rd_full_i),
    .nonempty_i (level_q != '0),
    .pop_o      (pop)
  );

  btq_trace_ptr #(.DEPTH(DEPTH)) u_tptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (en_rise),
    .cap_i     (cap_ok),
    .exec_i    (exec_i),
    .ptr_o     (trace_ptr_o)
  );

  assign level_sum = {1'b0, level_q} + (LW+1)'(cap_ok) - (LW+1)'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      level_q <= '0;
    end else begin
      en_q <= trace_en_i;
      if (level_sum > (LW+1)'(DEPTH)) level_q <= LW'(DEPTH);
      else                            level_q <= level_sum[LW-1:0];
    end
  end

  assign head = slots[PW'(level_q - 1'b1)];

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i && (level_q != '0) && head.vld) begin
      unique case (sel)
        SEL_FLAG: begin
          rd_data_o[31]        = 1'b1;
          rd_data_o[30]        = head.irq;
          rd_data_o[POS_W-1:0] = head.pos;
        end
        SEL_SRC: if (rd_full_i) rd_data_o = head.src;
        SEL_DST: if (rd_full_i) rd_data_o = head.dst;
        default: rd_data_o = '0;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign valid_o[g] = slots[g].vld && (level_q > LW'(g));
  end

  assign level_o = level_q;
endmodule

// File: rtl/branch_trace_queue_chk.sv
`timescale 1ns/1ps
module branch_trace_queue_chk #(
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic [1:0]       rd_sel_i,
  input logic             rd_full_i,
  input logic [31:0]      rd_data_o,
  input logic [LW-1:0]    level_o,
  input logic [PW-1:0]    trace_ptr_o,
  input logic [DEPTH-1:0] valid_o,
  input logic             cap_ok,
  input logic             pop,
  input logic             en_rise
);
  p_grow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ok && !pop && (level_o < LW'(DEPTH)) |=> level_o == $past(level_o) + 1'b1);

  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ok && !pop && (level_o == LW'(DEPTH)) |=> level_o == LW'(DEPTH));

  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (level_o == '0) |-> rd_data_o == '0);

  p_narrow_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !rd_full_i && (rd_sel_i != 2'd0) |-> rd_data_o == '0);

  p_pop_shrink_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && !cap_ok |=> level_o == $past(level_o) - 1'b1);

  p_cap_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && cap_ok |=> $stable(level_o));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> (trace_ptr_o == '0) && (valid_o == '0));

  p_level_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise && !pop |=> $stable(level_o));
endmodule

bind branch_trace_queue branch_trace_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .rd_sel_i    (rd_sel_i),
  .rd_full_i   (rd_full_i),
  .rd_data_o   (rd_data_o),
  .level_o     (level_o),
  .trace_ptr_o (trace_ptr_o),
  .valid_o     (valid_o),
  .cap_ok      (cap_ok),
  .pop         (pop),
  .en_rise     (en_rise)
);

// File: tb/branch_trace_queue_test.sv
`timescale 1ns/1ps
module branch_trace_queue_test;
  localparam int D = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trace_en = 0, cap_valid = 0, cap_irq = 0, cap_known = 0, exec_p = 0;
  logic rd_en = 0, rd_full = 0;
  logic [1:0] cap_pos = 0, rd_sel = 0;
  logic [31:0] cap_src = 0, cap_dst = 0, rd_data;
  logic [2:0] level;
  logic [1:0] tptr;
  logic [3:0] valid;

  always #2.5 clk = ~clk;

  branch_trace_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .trace_en_i(trace_en), .cap_valid_i(cap_valid),
    .cap_src_i(cap_src), .cap_dst_i(cap_dst), .cap_pos_i(cap_pos), .cap_irq_i(cap_irq),
    .cap_dst_known_i(cap_known), .exec_i(exec_p), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_full_i(rd_full), .rd_data_o(rd_data), .level_o(level), .trace_ptr_o(tptr),
    .valid_o(valid)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // stimulus for the next cycle
  bit d_en, d_cap, d_irq, d_known, d_ex, d_rd, d_full;
  logic [1:0] d_pos, d_sel;
  logic [31:0] d_src, d_dst;
  // optional directed expectations
  bit x_on, xl_on, xt_on;
  logic [31:0] x_val;
  int xl_val, xt_val;
  string x_tag, xl_tag, xt_tag;

  // reference model
  logic [31:0] m_src[D], m_dst[D];
  logic [1:0]  m_pos[D];
  bit          m_irq[D], m_vld[D];
  int m_cnt = 0, m_pend = 0, m_seq = 0;
  bit m_enq = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd();
    int h;
    if (!d_rd || m_cnt == 0) return 32'h0;
    h = m_cnt - 1;
    if (!m_vld[h]) return 32'h0;
    case (d_sel)
      2'd0: return {1'b1, m_irq[h], 28'h0, m_pos[h]};
      2'd1: return d_full ? m_src[h] : 32'h0;
      2'd2: return d_full ? m_dst[h] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] model_valid();
    logic [3:0] v;
    for (int i = 0; i < D; i++) v[i] = m_vld[i] && (i < m_cnt);
    return v;
  endfunction

  function automatic int model_tp();
    return (m_pend == 0) ? 0 : m_pend - 1;
  endfunction

  task automatic model_step();
    bit rise, capok, pop;
    int c, p;
    rise  = d_en && !m_enq;
    capok = d_en && m_enq && d_cap;
    pop   = d_rd && d_sel == 2'd2 && d_full && m_seq == 2 && m_cnt > 0;
    if (d_rd) begin
      case (d_sel)
        2'd0: m_seq = 1;
        2'd1: if (d_full) m_seq = (m_seq == 1) ? 2 : 0;
        2'd2: if (d_full) m_seq = 0;
        default: m_seq = 0;
      endcase
    end
    if (rise) for (int i = 0; i < D; i++) m_vld[i] = 0;
    if (capok) begin
      for (int i = D - 1; i > 0; i--) begin
        m_src[i] = m_src[i-1]; m_dst[i] = m_dst[i-1]; m_pos[i] = m_pos[i-1];
        m_irq[i] = m_irq[i-1]; m_vld[i] = m_vld[i-1];
      end
      m_src[0] = d_src; m_dst[0] = d_dst; m_pos[0] = d_pos;
      m_irq[0] = d_irq; m_vld[0] = d_known;
    end
    c = m_cnt + int'(capok) - int'(pop);
    m_cnt = (c > D) ? D : c;
    if (rise) m_pend = 0;
    else begin
      p = m_pend + int'(capok) - int'(d_ex && m_pend > 0);
      m_pend = (p > D) ? D : p;
    end
    m_enq = d_en;
  endtask

  task automatic tick();
    @(negedge clk);
    trace_en = d_en; cap_valid = d_cap; cap_src = d_src; cap_dst = d_dst;
    cap_pos = d_pos; cap_irq = d_irq; cap_known = d_known; exec_p = d_ex;
    rd_en = d_rd; rd_sel = d_sel; rd_full = d_full;
    #1;
    chk((d_rd && !d_full && d_sel != 0) ? "R4 narrow read" : "R3 read data",
        rd_data, model_rd());
    chk("R5 level", 32'(level), 32'(m_cnt));
    chk("R7 trace pointer", 32'(tptr), 32'(model_tp()));
    chk("R9 valid flags", 32'(valid), 32'(model_valid()));
    if (x_on)  chk(x_tag, rd_data, x_val);
    if (xl_on) chk(xl_tag, 32'(level), 32'(xl_val));
    if (xt_on) chk(xt_tag, 32'(tptr), 32'(xt_val));
    @(posedge clk);
    model_step();
    d_cap = 0; d_ex = 0; d_rd = 0; d_full = 1; x_on = 0; xl_on = 0; xt_on = 0;
  endtask

  task automatic push(logic [31:0] s, logic [31:0] t, logic [1:0] p, bit irq, bit known);
    d_cap = 1; d_src = s; d_dst = t; d_pos = p; d_irq = irq; d_known = known;
    tick();
  endtask

  task automatic rd(logic [1:0] sel, bit full);
    d_rd = 1; d_sel = sel; d_full = full;
    tick();
  endtask

  task automatic drain();
    while (m_cnt > 0) begin
      rd(2'd0, 1); rd(2'd1, 1); rd(2'd2, 1);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < D; i++) begin
      m_src[i] = 0; m_dst[i] = 0; m_pos[i] = 0; m_irq[i] = 0; m_vld[i] = 0;
    end
    d_en = 0; d_full = 1; d_known = 1; d_sel = 0; d_pos = 0; d_src = 0; d_dst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    x_on = 1; x_tag = "R1 reset read"; x_val = 0;
    xl_on = 1; xl_tag = "R1 reset level"; xl_val = 0;
    xt_on = 1; xt_tag = "R1 reset pointer"; xt_val = 0;
    rd(2'd0, 1);

    // enabling cycle ignores capture (R8)
    d_en = 1;
    push(32'hdead, 32'hbeef, 2'd0, 0, 1);
    xl_on = 1; xl_tag = "R8 no capture on enabling cycle"; xl_val = 0;
    push(32'h1000, 32'h2000, 2'd2, 0, 1);
    x_on = 1; x_tag = "R3 flag word"; x_val = 32'h8000_0002; rd(2'd0, 1);
    x_on = 1; x_tag = "R3 source word"; x_val = 32'h1000; rd(2'd1, 1);
    x_on = 1; x_tag = "R3 destination word"; x_val = 32'h2000; rd(2'd2, 1);
    xl_on = 1; xl_tag = "R5 popped after destination"; xl_val = 0; tick();

    // R2 overflow
    for (int i = 0; i < 5; i++)
      push(32'h100 + i, 32'h200 + i, 2'(i), i == 4, 1);
    xl_on = 1; xl_tag = "R2 level saturates"; xl_val = 4;
    xt_on = 1; xt_tag = "R7 pointer at top"; xt_val = 3;
    x_on = 1; x_tag = "R2 oldest dropped"; x_val = 32'h8000_0001;
    rd(2'd0, 1);

    // R4 narrow accesses keep the sequence
    x_on = 1; x_tag = "R4 narrow source"; x_val = 0; rd(2'd1, 0);
    x_on = 1; x_tag = "R4 narrow destination"; x_val = 0; rd(2'd2, 0);
    xl_on = 1; xl_tag = "R4 no pop on narrow"; xl_val = 4;
    x_on = 1; x_tag = "R3 head source"; x_val = 32'h101; rd(2'd1, 1);
    x_on = 1; x_tag = "R3 head destination"; x_val = 32'h201; rd(2'd2, 1);
    xl_on = 1; xl_tag = "R5 pop after full sequence"; xl_val = 3; tick();

    // R5 out-of-order reads do not pop
    rd(2'd1, 1); rd(2'd2, 1);
    rd(2'd0, 1); rd(2'd2, 1);
    rd(2'd0, 1); rd(2'd3, 1); rd(2'd1, 1); rd(2'd2, 1);
    xl_on = 1; xl_tag = "R5 no pop out of order"; xl_val = 3; tick();

    // R6 capture and pop together
    rd(2'd0, 1); rd(2'd1, 1);
    d_rd = 1; d_sel = 2'd2; d_full = 1;
    push(32'h300, 32'h400, 2'd1, 0, 1);
    xl_on = 1; xl_tag = "R6 level unchanged"; xl_val = 3;
    x_on = 1; x_tag = "R6 head after capture and pop"; x_val = 32'h8000_0003;
    rd(2'd0, 1);

    // R7 exec walks down and stops
    d_ex = 1; tick();
    xt_on = 1; xt_tag = "R7 exec moves down"; xt_val = 2; tick();
    repeat (5) begin d_ex = 1; tick(); end
    xt_on = 1; xt_tag = "R7 pointer floor"; xt_val = 0; tick();
    push(32'h600, 32'h700, 2'd0, 0, 1);
    xt_on = 1; xt_tag = "R7 first capture at bottom"; xt_val = 0;
    push(32'h610, 32'h710, 2'd0, 0, 1);
    xt_on = 1; xt_tag = "R7 capture moves up"; xt_val = 1; tick();

    // R8 disable then re-enable
    begin
      int lv;
      lv = m_cnt;
      d_en = 0;
      push(32'h900, 32'h901, 2'd0, 0, 1);
      xl_on = 1; xl_tag = "R8 no capture while off"; xl_val = lv;
      d_en = 1; tick();
      xl_on = 1; xl_tag = "R8 level kept"; xl_val = lv;
      xt_on = 1; xt_tag = "R8 pointer restarts"; xt_val = 0;
      x_on = 1; x_tag = "R8 stale entry reads zero"; x_val = 0;
      rd(2'd0, 1);
      chk("R8 valid cleared", 32'(valid), 32'h0);
    end

    // R9 unknown destination
    drain();
    push(32'h500, 32'h501, 2'd3, 0, 0);
    xl_on = 1; xl_tag = "R9 occupies slot"; xl_val = 1;
    x_on = 1; x_tag = "R9 unknown destination reads zero"; x_val = 0;
    rd(2'd0, 1);
    x_on = 1; x_tag = "R9 source reads zero"; x_val = 0; rd(2'd1, 1);
    chk("R9 valid flag clear", 32'(valid), 32'h0);
    rd(2'd2, 1);
    push(32'h800, 32'hffe0, 2'd1, 1, 1);
    x_on = 1; x_tag = "R3 interrupt flag"; x_val = 32'hC000_0001; rd(2'd0, 1);
    rd(2'd1, 1);
    x_on = 1; x_tag = "R3 handler start"; x_val = 32'hffe0; rd(2'd2, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(63) == 0) d_en = ~d_en;
      d_cap = ($urandom_range(2) == 0);
      d_src = $urandom; d_dst = $urandom; d_pos = 2'($urandom);
      d_irq = ($urandom_range(3) == 0); d_known = ($urandom_range(7) != 0);
      d_ex = ($urandom_range(3) == 0);
      d_rd = $urandom_range(1); d_sel = 2'($urandom); d_full = ($urandom_range(7) != 0);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule